// File: doc/BRIEF.md
# MSI Doorbell Write Receiver

This block is the bus-facing entry point of a per-hart interrupt controller that takes message-signaled interrupts. Its address window is divided into 4 KiB pages, and each page belongs to one interrupt file. A page can be the supervisor or machine file, or a guest file. A device signals an interrupt by storing a 32-bit word into the little-endian doorbell of a page. The stored word is not register contents. It is the identity number of the interrupt to mark pending.

When a doorbell store is well formed, the block turns the value into a one-cycle set-pending strobe. The strobe carries the identity and the page index and goes to the interrupt file array, which holds the pending and enable bits and the priority logic. That array also re-evaluates the external interrupt line of the affected page.

Malformed accesses raise a one-cycle error pulse. A store of identity zero, or of an identity that is too large, is dropped without an error. Every read gets a response with zero data.

Top module: `msi_doorbell_rx`

## Requirements
- R1: An access (read or write) whose address bits [1:0] are not both zero raises `err` for one cycle, in the cycle after the access, and produces no set strobe.
- R2: An access whose address is at or beyond NUM_PAGES × 4096 raises `err` one cycle later and produces no set strobe.
- R3: The page carried on `set_page` equals the access address shifted right by 12 (page shift).
- R4: A write to in-page offset 0x000 whose data lies in 1..NUM_IDS-1 produces `set_valid` high for exactly the next cycle, with `set_id` equal to the data and `set_page` equal to the page. `err` stays low.
- R5: A write to in-page offset 0x000 whose data is 0, or is NUM_IDS or above (compared over all 32 bits), produces neither `set_valid` nor `err`.
- R6: A write to any in-page offset other than 0x000, including the big-endian doorbell at 0x004, raises `err` and no set strobe.
- R7: A read at in-page offset 0x000 or 0x004 produces `rd_valid` one cycle later with `rd_data` zero, and no `err`.
- R8: A read at any other offset, or a read that fails R1 or R2, still produces `rd_valid` with zero data, and also raises `err` in the same cycle.
- R9: Each accepted access gives its outputs in the single cycle after it, so back-to-back accesses give back-to-back results in order. `set_valid` and `err` are never high together.
- R10: During and right after reset, `set_valid`, `err` and `rd_valid` are low. With no access, they stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address within the window |
| acc_wdata | input | DATA_W | Write data (identity for doorbell stores) |
| rd_valid | output | 1 | Read response, one cycle after a read |
| rd_data | output | DATA_W | Read data, always zero |
| err | output | 1 | One-cycle pulse for a malformed access |
| set_valid | output | 1 | One-cycle set-pending strobe |
| set_page | output | PAGE_W | Page index of the strobe |
| set_id | output | ID_W | Interrupt identity of the strobe |

## Verification
The hardest case is an identity value that is out of range only in its upper bits, such as 0x8000_0001. It has a small valid-looking low part and must still be dropped without an error. The bench stores it alongside the exact boundary values NUM_IDS-1 and NUM_IDS. It also places the last aligned word of the top page next to the first address beyond the window. Two doorbell stores to different pages go out in consecutive cycles, so two strobes come back to back, and the scoreboard has to pair each result with the right access.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

   // Classification of one bus access by the address decoder
   typedef enum logic [1:0] {
      ACC_ERR      = 2'd0,   // malformed: misaligned, out of window, bad offset
      ACC_DOORBELL = 2'd1,   // write to the little-endian doorbell offset
      ACC_READ     = 2'd2    // read at either doorbell offset
   } acc_kind_e;

   localparam int unsigned OFF_LE = 0;
   localparam int unsigned OFF_BE = 4;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
   import msi_rx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int NUM_PAGES  = 4,
   parameter int PAGE_W     = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_write,
   output acc_kind_e         kind,
   output logic [PAGE_W-1:0] page
);

   localparam int PFULL_W = ADDR_W - PAGE_SHIFT;
   localparam logic [PFULL_W-1:0] PAGE_LIMIT = PFULL_W'(NUM_PAGES);
   localparam logic [PAGE_SHIFT-1:0] LE_OFF = PAGE_SHIFT'(OFF_LE);
   localparam logic [PAGE_SHIFT-1:0] BE_OFF = PAGE_SHIFT'(OFF_BE);

   logic [PFULL_W-1:0]    page_full;
   logic [PAGE_SHIFT-1:0] offset;
   logic                  aligned;
   logic                  in_window;

   assign page_full = addr[ADDR_W-1:PAGE_SHIFT];
   assign offset    = addr[PAGE_SHIFT-1:0];
   assign aligned   = (addr[1:0] == 2'b00);
   assign in_window = (page_full < PAGE_LIMIT);
   assign page      = page_full[PAGE_W-1:0];

   always_comb begin
      kind = ACC_ERR;
      if (aligned && in_window) begin
         if (is_write) begin
            if (offset == LE_OFF) kind = ACC_DOORBELL;
         end else begin
            if (offset == LE_OFF || offset == BE_OFF) kind = ACC_READ;
         end
      end
   end

endmodule

// File: rtl/msi_id_check.sv
module msi_id_check #(
   parameter int DATA_W  = 32,
   parameter int NUM_IDS = 64,
   parameter int ID_W    = 6
) (
   input  logic [DATA_W-1:0] value,
   output logic              id_ok,
   output logic [ID_W-1:0]   id
);

   assign id = value[ID_W-1:0];

   generate
      if ((NUM_IDS & (NUM_IDS - 1)) == 0) begin : g_pow2
         // Power-of-two identity count: range test is an upper-bits-zero test
         assign id_ok = (value[DATA_W-1:ID_W] == '0) && (value[ID_W-1:0] != '0);
      end else begin : g_cmp
         localparam logic [DATA_W-1:0] ID_LIMIT = DATA_W'(NUM_IDS);
         assign id_ok = (value != '0) && (value < ID_LIMIT);
      end
   endgenerate

endmodule

// File: rtl/msi_doorbell_rx.sv
module msi_doorbell_rx
   import msi_rx_pkg::*;
#(
   parameter int NUM_PAGES  = 4,
   parameter int NUM_IDS    = 64,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12,
   localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
   localparam int ID_W      = $clog2(NUM_IDS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              err,
   output logic              set_valid,
   output logic [PAGE_W-1:0] set_page,
   output logic [ID_W-1:0]   set_id
);

   // Elaboration-time parameter checks
   generate
      if (NUM_PAGES < 1) begin : g_bad_pages
         $error("NUM_PAGES must be at least 1");
      end
      if (NUM_IDS < 2 || ID_W >= DATA_W) begin : g_bad_ids
         $error("NUM_IDS out of range for DATA_W");
      end
      if (PAGE_SHIFT < 3 || PAGE_SHIFT + PAGE_W > ADDR_W) begin : g_bad_shift
         $error("PAGE_SHIFT does not fit ADDR_W");
      end
   endgenerate

   acc_kind_e         kind;
   logic [PAGE_W-1:0] dec_page;
   logic              id_ok;
   logic [ID_W-1:0]   id_val;

   msi_addr_decode #(
      .ADDR_W     (ADDR_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .NUM_PAGES  (NUM_PAGES),
      .PAGE_W     (PAGE_W)
   ) u_decode (
      .addr     (acc_addr),
      .is_write (acc_write),
      .kind     (kind),
      .page     (dec_page)
   );

   msi_id_check #(
      .DATA_W  (DATA_W),
      .NUM_IDS (NUM_IDS),
      .ID_W    (ID_W)
   ) u_idchk (
      .value (acc_wdata),
      .id_ok (id_ok),
      .id    (id_val)
   );

   logic fire_set;
   assign fire_set = acc_valid && acc_write && (kind == ACC_DOORBELL) && id_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         set_valid <= 1'b0;
         set_page  <= '0;
         set_id    <= '0;
         err       <= 1'b0;
         rd_valid  <= 1'b0;
      end else begin
         set_valid <= fire_set;
         if (fire_set) begin
            set_page <= dec_page;
            set_id   <= id_val;
         end
         err      <= acc_valid && (kind == ACC_ERR);
         rd_valid <= acc_valid && !acc_write;
      end
   end

   assign rd_data = '0;

   // R9
   no_dual_event_chk: assert property (@(posedge clk) disable iff (rst)
      !(set_valid && err));

   // R4
   set_cause_chk: assert property (@(posedge clk) disable iff (rst)
      set_valid |-> $past(acc_valid && acc_write));

   // R5
   set_id_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      set_valid |-> (set_id != '0));

   // R8
   err_cause_chk: assert property (@(posedge clk) disable iff (rst)
      err |-> $past(acc_valid));

   // R7
   rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> $past(acc_valid && !acc_write));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(acc_valid) |-> (!set_valid && !err && !rd_valid));

endmodule

// File: tb/tb_msi_doorbell_rx.sv
module tb_msi_doorbell_rx;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_PAGES  = 4;
   localparam int NUM_IDS    = 64;
   localparam int ADDR_W     = 32;
   localparam int DATA_W     = 32;
   localparam int PAGE_W     = 2;
   localparam int ID_W       = 6;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              acc_valid = 1'b0;
   logic              acc_write = 1'b0;
   logic [ADDR_W-1:0] acc_addr  = '0;
   logic [DATA_W-1:0] acc_wdata = '0;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic              err;
   logic              set_valid;
   logic [PAGE_W-1:0] set_page;
   logic [ID_W-1:0]   set_id;

   msi_doorbell_rx #(
      .NUM_PAGES (NUM_PAGES),
      .NUM_IDS   (NUM_IDS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PAGE_SHIFT(12)
   ) dut (
      .clk       (clk),
      .rst       (rst),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .err       (err),
      .set_valid (set_valid),
      .set_page  (set_page),
      .set_id    (set_id)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          cyc;
      logic        e_set;
      logic [1:0]  e_page;
      logic [5:0]  e_id;
      logic        e_err;
      logic        e_rd;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   bit   mon_on = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                         input logic es, input logic [1:0] ep, input logic [5:0] ei,
                         input logic ee, input string tag);
      exp_t it;
      @(negedge clk);
      acc_valid = 1'b1;
      acc_write = wr;
      acc_addr  = a;
      acc_wdata = d;
      it.cyc = cyc; it.e_set = es; it.e_page = ep; it.e_id = ei;
      it.e_err = ee; it.e_rd = !wr; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
   endtask

   // Monitor: pops one expectation per access, one cycle after it was driven
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
               exp_t it;
               bit bad;
               it = exp_q.pop_front();
               checks++;
               bad = (set_valid !== it.e_set) || (err !== it.e_err) ||
                     (rd_valid !== it.e_rd) || (it.e_rd && rd_data !== '0) ||
                     (it.e_set && (set_page !== it.e_page || set_id !== it.e_id));
               if (bad) begin
                  errors++;
                  $display("FAIL %s: got set=%b page=%0d id=%0d err=%b rd=%b rdata=%h, exp set=%b page=%0d id=%0d err=%b rd=%b rdata=0",
                           it.tag, set_valid, set_page, set_id, err, rd_valid, rd_data,
                           it.e_set, it.e_page, it.e_id, it.e_err, it.e_rd);
               end
            end else if (set_valid || err || rd_valid) begin
               errors++;
               $display("FAIL R10 idle: got set=%b err=%b rd=%b, exp all 0",
                        set_valid, err, rd_valid);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout, exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs low while in reset
      checks++;
      if (set_valid || err || rd_valid) begin
         errors++;
         $display("FAIL R10 reset: got set=%b err=%b rd=%b, exp 0 0 0", set_valid, err, rd_valid);
      end
      rst = 1'b0;
      @(negedge clk);
      mon_on = 1;
      repeat (2) @(negedge clk);

      // R4 / R3: valid doorbell stores
      access(1, 32'h0000_0000, 32'd5,  1, 2'd0, 6'd5,  0, "R4 page0 id5");  idle();
      access(1, 32'h0000_2000, 32'd63, 1, 2'd2, 6'd63, 0, "R4 max id");     idle();
      access(1, 32'h0000_3000, 32'd1,  1, 2'd3, 6'd1,  0, "R3 top page");   idle();
      // R5: dropped values
      access(1, 32'h0000_1000, 32'd0,          0, 0, 0, 0, "R5 zero");      idle();
      access(1, 32'h0000_1000, 32'd64,         0, 0, 0, 0, "R5 NUM_IDS");   idle();
      access(1, 32'h0000_1000, 32'h8000_0001,  0, 0, 0, 0, "R5 high bits"); idle();
      // R1: misaligned
      access(1, 32'h0000_1002, 32'd3, 0, 0, 0, 1, "R1 write misaligned");   idle();
      access(0, 32'h0000_0001, 32'd0, 0, 0, 0, 1, "R1 read misaligned");    idle();
      // R2: out of window
      access(1, 32'h0000_4000, 32'd3, 0, 0, 0, 1, "R2 first beyond");       idle();
      access(0, 32'h0000_7FFC, 32'd0, 0, 0, 0, 1, "R2 read beyond");        idle();
      access(1, 32'h1000_0000, 32'd3, 0, 0, 0, 1, "R2 far beyond");         idle();
      // R6: other in-page offsets
      access(1, 32'h0000_1004, 32'd3, 0, 0, 0, 1, "R6 BE doorbell write");  idle();
      access(1, 32'h0000_3FFC, 32'd3, 0, 0, 0, 1, "R6 last word write");    idle();
      // R7 / R8: reads
      access(0, 32'h0000_2000, 32'd0, 0, 0, 0, 0, "R7 read LE");            idle();
      access(0, 32'h0000_2004, 32'd0, 0, 0, 0, 0, "R7 read BE");            idle();
      access(0, 32'h0000_2010, 32'd0, 0, 0, 0, 1, "R8 read bad offset");    idle();
      // R9: back-to-back results
      access(1, 32'h0000_0000, 32'd7, 1, 2'd0, 6'd7, 0, "R9 b2b first");
      access(1, 32'h0000_1000, 32'd9, 1, 2'd1, 6'd9, 0, "R9 b2b second");
      access(1, 32'h0000_1008, 32'd9, 0, 0, 0, 1,       "R9 b2b error");
      access(0, 32'h0000_3004, 32'd0, 0, 0, 0, 0,       "R9 b2b read");
      idle();

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R9 drain: got %0d pending, exp 0", exp_q.size());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule